// File: doc/BRIEF.md
# Watermark Write Drain Controller

This block decides, cycle by cycle, which way a shared bidirectional memory data bus is driven. Read mode is the default, and reads go out as bus commands when they arrive. Writes do not go straight to the bus. They wait in a bounded write buffer. When the buffer holds a high-watermark number of entries, the controller stops taking reads and turns the bus around. It then issues the buffered writes one per cycle, oldest first, until the buffer is down to a low watermark. After that it turns the bus back to read mode. Reversing the bus always costs a fixed number of idle turnaround cycles. The hysteresis between the two watermarks groups writes into bursts, so the bus changes direction rarely.

A read whose address matches a write still in the buffer does not go to the bus. It is answered at once with the newest buffered data for that address. Write enqueue is back-pressured when the buffer is full. Elaboration fails unless the low watermark is below the high watermark, the high watermark is no larger than the depth, and the turnaround length is at least one cycle.

Default parameters: 8-bit address, 16-bit data, depth 8, high watermark 6, low watermark 2, turnaround of 3 cycles.

Top module: `wdrain_ctrl`

## Requirements
- R1: After reset the buffer is empty, `rd_ready` and `wr_ready` are 1, and `cmd_valid` and `byp_valid` are 0.
- R2: In read mode with fewer than HI_MARK entries buffered, a request on `rd_valid` is accepted in the same cycle. If it misses the buffer, it appears in that cycle as `cmd_valid`=1 and `cmd_write`=0, with `cmd_addr` equal to `rd_addr`. With no read pending in that mode, no command is issued.
- R3: A write is taken on a cycle where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 0 exactly while DEPTH entries are held, and it returns to 1 in the cycle after a write is drained.
- R4: In the first read-mode cycle in which HI_MARK or more entries are held, `rd_ready` is 0 and no command is issued. The first write command appears exactly TURN_CYC cycles after that cycle, and every cycle in between is idle.
- R5: In write mode, one buffered write is issued in every cycle (`cmd_valid`=1, `cmd_write`=1, with its address and data), in enqueue order. Draining continues until the occupancy after the cycle's dequeue and enqueue is at most LO_MARK.
- R6: After the last write of a drain come exactly TURN_CYC idle cycles with `rd_ready`=0. In the next cycle `rd_ready` is 1 again, and a pending read is issued.
- R7: An accepted read whose address matches a buffered entry gives `byp_valid`=1 in the same cycle. `byp_data` carries the data of the youngest matching entry, and `cmd_valid` is 0. Once an entry has been drained, a read of its address goes to the bus.
- R8: `rd_ready` is 0 during both turnarounds and during write mode. Any two commands in opposite directions are separated by at least TURN_CYC idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request pending |
| rd_addr | input | AW | Read request address |
| rd_ready | output | 1 | Read request accepted this cycle if valid |
| wr_valid | input | 1 | Write enqueue request |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_ready | output | 1 | Buffer can take a write this cycle |
| cmd_valid | output | 1 | Bus command issued this cycle |
| cmd_write | output | 1 | Command direction: 1 write, 0 read |
| cmd_addr | output | AW | Command address |
| cmd_data | output | DW | Write data of the command (0 for reads) |
| byp_valid | output | 1 | Read answered from the write buffer |
| byp_data | output | DW | Forwarded write data |

## Verification
The bench puts two writes to the same address in the buffer and reads that address. A design that scanned the buffer in the wrong order would return the stale value. It counts the exact cycles from reaching the high watermark to the first write, and from the last write back to read mode. An off-by-one turnaround counter would issue a command one cycle early or late. It also fills the buffer during a turnaround, so `wr_ready` must drop at full and recover only after the first drained write. A controller that stopped draining at the wrong occupancy would show a missing or extra write. Reads of drained addresses must go to the bus, so a design that forwarded from freed entries would produce a bypass where a bus read was expected.

// File: rtl/wdrain_pkg.sv
package wdrain_pkg;

    typedef enum logic [1:0] {
        MODE_RD = 2'd0,
        MODE_TW = 2'd1,
        MODE_WR = 2'd2,
        MODE_TR = 2'd3
    } mode_e;

    function automatic logic in_write_dir(input mode_e m);
        return (m == MODE_WR);
    endfunction

endpackage

// File: rtl/wdrain_buf.sv
module wdrain_buf #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count,
    output logic          full,
    input  logic [AW-1:0] look_addr,
    output logic          hit,
    output logic [DW-1:0] hit_data
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [AW-1:0] mem_a [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                mem_a[wp] <= push_addr;
                mem_d[wp] <= push_data;
                wp        <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (pop) begin
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            end
            if (push && !pop) begin
                cnt <= cnt + 1'b1;
            end else if (pop && !push) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign head_addr = mem_a[rp];
    assign head_data = mem_d[rp];
    assign count     = cnt;
    assign full      = (cnt == FULL);

    // oldest to youngest scan; a later match overrides an earlier one
    always_comb begin
        logic [PW:0] s;
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            s = {1'b0, rp} + (PW+1)'(i);
            if (s >= (PW+1)'(DEPTH)) begin
                s = s - (PW+1)'(DEPTH);
            end
            if ((CW'(i) < cnt) && (mem_a[s[PW-1:0]] == look_addr)) begin
                hit      = 1'b1;
                hit_data = mem_d[s[PW-1:0]];
            end
        end
    end

endmodule

// File: rtl/wdrain_seq.sv
module wdrain_seq
    import wdrain_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int HI_MARK  = 6,
    parameter int LO_MARK  = 2,
    parameter int TURN_CYC = 3,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int TW      = $clog2(TURN_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic          push,
    output mode_e         mode
);

    localparam logic [CW-1:0] HI_C   = CW'(HI_MARK);
    localparam logic [CW:0]   STOP_C = (CW+1)'(LO_MARK + 1);
    localparam logic [TW-1:0] LD_W   = TW'((TURN_CYC > 1) ? TURN_CYC - 2 : 0);
    localparam logic [TW-1:0] LD_R   = TW'(TURN_CYC - 1);

    mode_e         st;
    logic [TW-1:0] tcnt;
    logic [CW:0]   after_sum;

    // occupancy after this cycle's pop, plus one
    assign after_sum = {1'b0, count} + {{CW{1'b0}}, push};

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= MODE_RD;
            tcnt <= '0;
        end else begin
            unique case (st)
                MODE_RD: begin
                    if (count >= HI_C) begin
                        st   <= (TURN_CYC == 1) ? MODE_WR : MODE_TW;
                        tcnt <= LD_W;
                    end
                end
                MODE_TW: begin
                    if (tcnt == '0) begin
                        st <= MODE_WR;
                    end else begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
                MODE_WR: begin
                    if (after_sum <= STOP_C) begin
                        st   <= MODE_TR;
                        tcnt <= LD_R;
                    end
                end
                MODE_TR: begin
                    if (tcnt == '0) begin
                        st <= MODE_RD;
                    end else begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
                default: st <= MODE_RD;
            endcase
        end
    end

    assign mode = st;

endmodule

// File: rtl/wdrain_ctrl.sv
module wdrain_ctrl
    import wdrain_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int DEPTH    = 8,
    parameter int HI_MARK  = 6,
    parameter int LO_MARK  = 2,
    parameter int TURN_CYC = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ready,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    output logic          cmd_valid,
    output logic          cmd_write,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data,
    output logic          byp_valid,
    output logic [DW-1:0] byp_data
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] HI_C = CW'(HI_MARK);

    if (LO_MARK < 0 || LO_MARK >= HI_MARK || HI_MARK > DEPTH || TURN_CYC < 1) begin : g_bad_cfg
        $error("wdrain_ctrl: need 0 <= LO_MARK < HI_MARK <= DEPTH and TURN_CYC >= 1");
    end

    mode_e         mode;
    logic [CW-1:0] count;
    logic          full, hit, push, pop, rd_fire, wdir;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data, hit_data;

    assign wdir     = in_write_dir(mode);
    assign wr_ready = !full;
    assign push     = wr_valid && wr_ready;
    assign pop      = wdir;
    assign rd_ready = (mode == MODE_RD) && (count < HI_C);
    assign rd_fire  = rd_valid && rd_ready;

    wdrain_buf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .pop       (pop),
        .head_addr (head_addr),
        .head_data (head_data),
        .count     (count),
        .full      (full),
        .look_addr (rd_addr),
        .hit       (hit),
        .hit_data  (hit_data)
    );

    wdrain_seq #(
        .DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .TURN_CYC(TURN_CYC)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .count (count),
        .push  (push),
        .mode  (mode)
    );

    assign byp_valid = rd_fire && hit;
    assign byp_data  = hit_data;
    assign cmd_valid = (rd_fire && !hit) || wdir;
    assign cmd_write = wdir;
    assign cmd_addr  = wdir ? head_addr : rd_addr;
    assign cmd_data  = wdir ? head_data : '0;

endmodule

// File: rtl/wdrain_chk.sv
module wdrain_chk #(
    parameter int AW       = 8,
    parameter int DEPTH    = 8,
    parameter int LO_MARK  = 2,
    parameter int TURN_CYC = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_valid,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ready,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic          cmd_valid,
    input logic          cmd_write,
    input logic [AW-1:0] cmd_addr,
    input logic          byp_valid
);

    int occ, occ_after, idle;
    logic seen, last_w, acc, drn;

    assign acc       = wr_valid && wr_ready;
    assign drn       = cmd_valid && cmd_write;
    assign occ_after = occ + (acc ? 1 : 0) - (drn ? 1 : 0);

    always_ff @(posedge clk) begin
        if (rst) begin
            occ    <= 0;
            idle   <= 0;
            seen   <= 1'b0;
            last_w <= 1'b0;
        end else begin
            occ <= occ_after;
            if (cmd_valid) begin
                idle   <= 0;
                seen   <= 1'b1;
                last_w <= cmd_write;
            end else if (idle < TURN_CYC) begin
                idle <= idle + 1;
            end
        end
    end

    // R2
    rd_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_write) |-> (rd_valid && rd_ready && cmd_addr == rd_addr));

    // R3
    full_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ready == (occ < DEPTH)) && (occ <= DEPTH));

    // R5
    drain_cont_chk: assert property (@(posedge clk) disable iff (rst)
        (drn && occ_after > LO_MARK) |=> (cmd_valid && cmd_write));

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        byp_valid |-> (rd_valid && rd_ready && !cmd_valid));

    // R8
    turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && seen && cmd_write != last_w) |-> (idle >= TURN_CYC));

    // R8
    no_read_in_wr_chk: assert property (@(posedge clk) disable iff (rst)
        drn |-> !rd_ready);

endmodule

bind wdrain_ctrl wdrain_chk #(
    .AW(AW), .DEPTH(DEPTH), .LO_MARK(LO_MARK), .TURN_CYC(TURN_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .rd_ready  (rd_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .byp_valid (byp_valid)
);

// File: tb/test_wdrain_ctrl.sv
module test_wdrain_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_valid, wr_valid;
    logic [7:0]  rd_addr, wr_addr;
    logic [15:0] wr_data;
    logic        rd_ready, wr_ready, cmd_valid, cmd_write, byp_valid;
    logic [7:0]  cmd_addr;
    logic [15:0] cmd_data, byp_data;

    int nchk = 0, nfail = 0, ncyc = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    wdrain_ctrl i_wdrain_ctrl (
        .clk(clk), .rst(rst),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .byp_valid(byp_valid), .byp_data(byp_data)
    );

    // {address, expect hit, expected forwarded data}
    localparam logic [24:0] RD_VEC [5] = '{
        {8'h10, 1'b1, 16'hB010},
        {8'h11, 1'b1, 16'hA001},
        {8'h20, 1'b0, 16'h0000},
        {8'h12, 1'b1, 16'hA002},
        {8'h33, 1'b0, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic exp_idle(input string req);
        chk({req, " cmd_valid idle"}, 32'(cmd_valid), 0);
        chk({req, " rd_ready low"}, 32'(rd_ready), 0);
    endtask

    task automatic exp_wr(input string req, input logic [7:0] a, input logic [15:0] d);
        chk({req, " write valid"}, {30'd0, cmd_valid, cmd_write}, 32'h3);
        chk({req, " write addr"}, 32'(cmd_addr), 32'(a));
        chk({req, " write data"}, 32'(cmd_data), 32'(d));
    endtask

    task automatic exp_rd(input string req, input logic [7:0] a);
        chk({req, " read cmd"}, {29'd0, rd_ready, cmd_valid, cmd_write}, 32'h6);
        chk({req, " read addr"}, 32'(cmd_addr), 32'(a));
        chk({req, " no bypass"}, 32'(byp_valid), 0);
    endtask

    task automatic exp_byp(input string req, input logic [15:0] d);
        chk({req, " bypass"}, {29'd0, rd_ready, byp_valid, cmd_valid}, 32'h6);
        chk({req, " bypass data"}, 32'(byp_data), 32'(d));
    endtask

    task automatic push_one(input logic [7:0] a, input logic [15:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        #1 chk("R3 wr_ready while space", 32'(wr_ready), 1);
        tick();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 5000 && !done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual %0d cycles expected under 5000", ncyc);
            finish_up();
        end
    end

    initial begin
        rst = 1'b1; rd_valid = 1'b0; rd_addr = '0;
        wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) tick();
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 rd_ready", 32'(rd_ready), 1);
        chk("R1 wr_ready", 32'(wr_ready), 1);
        chk("R1 cmd_valid", 32'(cmd_valid), 0);
        chk("R1 byp_valid", 32'(byp_valid), 0);
        tick();

        // four writes, two to the same address, below the high mark
        push_one(8'h10, 16'hA000);
        push_one(8'h11, 16'hA001);
        push_one(8'h12, 16'hA002);
        push_one(8'h10, 16'hB010);
        wr_valid = 1'b0;

        // R2 / R7 table of reads in read mode
        for (int v = 0; v < 5; v++) begin
            rd_valid = 1'b1;
            rd_addr  = RD_VEC[v][24:17];
            #1;
            if (RD_VEC[v][16]) exp_byp("R7 youngest match", RD_VEC[v][15:0]);
            else               exp_rd("R2 miss to bus", RD_VEC[v][24:17]);
            tick();
        end

        // R2 no write issued below the high mark with no read pending
        rd_valid = 1'b0;
        #1 chk("R2 no command when idle", 32'(cmd_valid), 0);
        tick();

        // reach the high mark
        push_one(8'h13, 16'hA003);
        push_one(8'h14, 16'hA004);
        wr_valid = 1'b0;
        rd_valid = 1'b1;
        rd_addr  = 8'h50;
        for (int k = 0; k < 11; k++) begin
            #1;
            if (k < 3) begin
                exp_idle("R4 turnaround into write");
            end else if (k < 7) begin
                case (k)
                    3: exp_wr("R5 drain order", 8'h10, 16'hA000);
                    4: exp_wr("R5 drain order", 8'h11, 16'hA001);
                    5: exp_wr("R5 drain order", 8'h12, 16'hA002);
                    default: exp_wr("R5 drain order", 8'h10, 16'hB010);
                endcase
            end else if (k < 10) begin
                exp_idle("R6 turnaround into read");
            end else begin
                exp_rd("R6 read resumes", 8'h50);
            end
            tick();
        end

        // R7 drained address now goes to the bus
        rd_addr = 8'h10;
        #1 exp_rd("R7 drained entry not forwarded", 8'h10);
        tick();
        rd_valid = 1'b0;

        // fill during the turnaround to hit full
        for (int i = 0; i < 4; i++) push_one(8'h60 + 8'(i), 16'hC060 + 16'(i));
        wr_valid = 1'b1; wr_addr = 8'h64; wr_data = 16'hC064;
        #1 chk("R4 rd_ready drops at high mark", 32'(rd_ready), 0);
        tick();
        wr_addr = 8'h65; wr_data = 16'hC065;
        #1 chk("R3 space during turnaround", 32'(wr_ready), 1);
        tick();
        wr_addr = 8'h66; wr_data = 16'hC066;
        #1 chk("R3 wr_ready low when full", 32'(wr_ready), 0);
        chk("R8 idle in turnaround", 32'(cmd_valid), 0);
        tick();
        #1 chk("R3 still full at first drain", 32'(wr_ready), 0);
        exp_wr("R5 first drain oldest", 8'h13, 16'hA003);
        tick();
        #1 chk("R3 wr_ready back after drain", 32'(wr_ready), 1);
        exp_wr("R5 second drain", 8'h14, 16'hA004);
        tick();
        wr_valid = 1'b0;
        for (int k = 0; k < 5; k++) begin
            #1 exp_wr("R5 continuous drain", 8'h60 + 8'(k), 16'hC060 + 16'(k));
            tick();
        end
        for (int k = 0; k < 3; k++) begin
            #1 exp_idle("R6 idle after drain");
            tick();
        end
        rd_valid = 1'b1; rd_addr = 8'h66;
        #1 exp_byp("R7 entry taken after full", 16'hC066);
        tick();
        rd_addr = 8'h65;
        #1 exp_byp("R7 remaining entry", 16'hC065);
        tick();
        rd_addr = 8'h13;
        #1 exp_rd("R2 miss after drain", 8'h13);
        tick();
        rd_valid = 1'b0;
        finish_up();
    end

endmodule